// File: doc/BRIEF.md
# UART Holding-Register Transmit Buffer

This block is the transmit side of a simple UART channel that has room for one waiting character. A bus master writes a byte into an 8-bit holding register, and the block moves that byte into a serial shift register when the shift register has nothing to send. A status output, `txReady`, tells the master whether the holding register can take another byte. A byte written while `txReady` is low is discarded, as is any byte written while the transmitter is disabled.

On the line side the block sends 8N1 frames on `txLine`. An external baud tick paces every bit. The shift register takes a waiting byte only on a baud tick while it is idle, or on the tick that ends a stop bit, and each frame begins on that tick. A byte written before the current stop bit ends therefore follows the previous frame with no idle time between them. The master can keep the line fully busy by writing a new byte each time `txReady` comes back.

Top module: `uart_hold_tx`

## Requirements
- R1: After reset `txReady` is 1 and `txLine` is 1, the line's idle level.
- R2: A write (`wrStrobe` high at a clock edge) made while `txReady` is 1 and `txEnable` is 1 is accepted. `txReady` is 0 in the cycle after that edge.
- R3: A write made while `txReady` is 0 has no effect. The byte already held is the one transmitted, and no extra frame goes out.
- R4: A write made while `txEnable` is 0 has no effect. `txReady` stays 1 and no frame goes out.
- R5: A held byte moves into the shift register only at a clock edge where `baudTick` is high and the shift register is idle or finishing its stop bit. `txReady` returns to 1 in the cycle after that edge, and at that point `txLine` is low (start bit).
- R6: Each frame is a low start bit, then data bits 0 through 7 (LSB first), then a high stop bit. Each bit lasts exactly one baud-tick period, and `txLine` changes only at edges where `baudTick` is high.
- R7: If the next byte is accepted before the current stop bit ends, its start bit begins at the very next tick. Consecutive frame starts are then exactly 10 tick periods apart.
- R8: When no byte is waiting, `txLine` stays high after the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter enable; writes are ignored while it is 0 |
| wrStrobe | input | 1 | Single-cycle write strobe for the holding register |
| wrData | input | 8 | Byte to load into the holding register |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| txReady | output | 1 | 1 when the holding register is empty and can accept a byte |
| txLine | output | 1 | Serial output, high when idle |

## Verification
The bench sweeps all 256 byte values back to back and decodes each frame from the line. A design that shifted bits MSB first, dropped the stop bit, or left an idle gap between frames would show a wrong byte or a frame start that arrives off the 40-cycle spacing. Writes made while `txReady` is low and writes made while the transmitter is disabled are both issued on purpose. A design that accepted either one would send an extra frame, send the wrong byte, or pull `txReady` low. The bench also checks that `txReady` comes back only on the cycle after a baud tick, with the start bit already on the line. A design that released the holding register early, or started frames between ticks, fails this check.

// File: rtl/uht_pkg.sv
package uht_pkg;
  typedef struct packed {
    logic acceptWr;
    logic loadShift;
    logic shiftBit;
  } txStrobes_t;
endpackage

// File: rtl/uht_ctrl.sv
module uht_ctrl
  import uht_pkg::*;
#(
  parameter int FRAME_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       wrStrobe,
  input  logic       baudTick,
  output txStrobes_t strobes,
  output logic       txReady
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic             holdFull;
  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             endOfFrame;

  always_comb begin
    endOfFrame        = busy & baudTick & (bitCnt == LAST_BIT);
    strobes.acceptWr  = wrStrobe & txEnable & ~holdFull;
    strobes.loadShift = holdFull & baudTick & (~busy | endOfFrame);
    strobes.shiftBit  = busy & baudTick & ~endOfFrame;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      busy     <= 1'b0;
      bitCnt   <= '0;
    end else begin
      if (strobes.acceptWr)       holdFull <= 1'b1;
      else if (strobes.loadShift) holdFull <= 1'b0;

      if (strobes.loadShift) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (endOfFrame) begin
        busy <= 1'b0;
      end else if (strobes.shiftBit) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign txReady = ~holdFull;
endmodule

// File: rtl/uht_dp.sv
module uht_dp
  import uht_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine
);
  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (strobes.acceptWr) holdReg <= wrData;
      if (strobes.loadShift)
        shiftReg <= {1'b1, holdReg, 1'b0};
      else if (strobes.shiftBit)
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign txLine = shiftReg[0];
endmodule

// File: rtl/uart_hold_tx.sv
module uart_hold_tx
  import uht_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              baudTick,
  output logic              txReady,
  output logic              txLine
);
  localparam int FRAME_W = DATA_W + 2;

  txStrobes_t strobes;

  uht_ctrl #(.FRAME_W(FRAME_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .txEnable (txEnable),
    .wrStrobe (wrStrobe),
    .baudTick (baudTick),
    .strobes  (strobes),
    .txReady  (txReady)
  );

  uht_dp #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .txLine  (txLine)
  );
endmodule

// File: rtl/uht_checker.sv
module uht_checker (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic wrStrobe,
  input logic baudTick,
  input logic txReady,
  input logic txLine
);
  a_r2_accept_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && txEnable && txReady) |=> !txReady);

  a_r3_full_holds_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!txReady && !baudTick) |=> !txReady);

  a_r4_ready_kept_without_write: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !(wrStrobe && txEnable)) |=> txReady);

  a_r5_release_starts_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> !txLine);

  a_r6_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txLine));
endmodule

bind uart_hold_tx uht_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .txEnable (txEnable),
  .wrStrobe (wrStrobe),
  .baudTick (baudTick),
  .txReady  (txReady),
  .txLine   (txLine)
);

// File: tb/uart_hold_tx_tb_top.sv
`timescale 1ns/1ps
module uart_hold_tx_tb_top;
  localparam int TICK_P  = 4;
  localparam int FRAME_C = 10 * TICK_P;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       baudTick = 1'b0;
  logic       txReady;
  logic       txLine;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int tickCnt = 0;
  bit finished = 1'b0;

  // line decoder state
  bit         rxBusy = 1'b0;
  int         rxR = 0;
  logic [7:0] rxByte = 8'h00;
  int         rxCount = 0;
  int         lastStart = 0;
  bit         haveLast = 1'b0;
  bit         chkGap = 1'b0;
  logic       prevReady = 1'b1;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  uart_hold_tx dut_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrStrobe(wrStrobe),
    .wrData(wrData), .baudTick(baudTick), .txReady(txReady), .txLine(txLine)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // monitor, decoder and baud-tick source, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "WDOG", "watchdog expired", cyc, 100000);
      finishRun();
    end
    if (rstN) begin
      // R5: ready rises only after a tick edge, with start bit on the line
      if (!prevReady && txReady) begin
        check(baudTick == 1'b1, "R5", "ready rose without tick", baudTick, 1);
        check(txLine == 1'b0, "R5", "line at ready release", txLine, 0);
      end
      prevReady = txReady;

      if (rxBusy) begin
        rxR++;
        if (rxR == FRAME_C) rxBusy = 1'b0;
      end
      if (!rxBusy && txLine == 1'b0) begin
        rxBusy = 1'b1;
        rxR = 0;
        if (chkGap && haveLast)
          check(cyc - lastStart == FRAME_C, "R7", "frame start spacing",
                cyc - lastStart, FRAME_C);
        lastStart = cyc;
        haveLast = 1'b1;
      end
      if (rxBusy) begin
        if (rxR == TICK_P / 2)
          check(txLine == 1'b0, "R6", "start bit", txLine, 0);
        if ((rxR % TICK_P) == TICK_P / 2 && rxR / TICK_P >= 1 && rxR / TICK_P <= 8)
          rxByte = {txLine, rxByte[7:1]};
        if (rxR == 9 * TICK_P + TICK_P / 2) begin
          check(txLine == 1'b1, "R6", "stop bit", txLine, 1);
          rxCount++;
          if (expQ.size() > 0) begin
            check(rxByte == expQ[0], "R6", "decoded byte", rxByte, expQ[0]);
            void'(expQ.pop_front());
          end else begin
            check(1'b0, "R3", "unexpected frame", rxByte, -1);
          end
        end
      end

      tickCnt = (tickCnt + 1) % TICK_P;
      baudTick = (tickCnt == 0);
    end
  end

  task automatic writeByte(input logic [7:0] v);
    @(negedge clk);
    wrData = v;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitReady();
    while (!txReady) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cnt0;
    bit allHigh;
    idle(3);
    // R1: reset state, sampled while reset is held
    check(txReady == 1'b1, "R1", "txReady in reset", txReady, 1);
    check(txLine == 1'b1, "R1", "txLine in reset", txLine, 1);
    rstN = 1'b1;
    idle(2);
    check(txReady == 1'b1, "R1", "txReady after reset", txReady, 1);
    check(txLine == 1'b1, "R1", "txLine after reset", txLine, 1);

    // R4: writes while disabled are ignored
    cnt0 = rxCount;
    writeByte(8'hA5);
    check(txReady == 1'b1, "R4", "ready after disabled write", txReady, 1);
    idle(60);
    check(rxCount == cnt0, "R4", "frames after disabled write", rxCount, cnt0);
    check(txLine == 1'b1, "R4", "line after disabled write", txLine, 1);

    // R2 and R3: accepted write, then one dropped while full
    txEnable = 1'b1;
    cnt0 = rxCount;
    expQ.push_back(8'h3C);
    @(negedge clk);
    wrData = 8'h3C;
    wrStrobe = 1'b1;
    @(negedge clk);
    check(txReady == 1'b0, "R2", "ready after accepted write", txReady, 0);
    wrData = 8'hFF;  // R3: this write meets a full holding register
    @(negedge clk);
    wrStrobe = 1'b0;
    idle(3 * FRAME_C);
    check(rxCount == cnt0 + 1, "R3", "frames after dropped write", rxCount, cnt0 + 1);

    // R8: line idles high once the frame is done
    allHigh = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1) allHigh = 1'b0;
    end
    check(allHigh, "R8", "idle line high", allHigh, 1);
    check(txReady == 1'b1, "R8", "ready when idle", txReady, 1);

    // R6 and R7: all byte values back to back
    cnt0 = rxCount;
    chkGap = 1'b1;
    haveLast = 1'b0;
    for (int v = 0; v < 256; v++) begin
      waitReady();
      expQ.push_back(v[7:0]);
      writeByte(v[7:0]);
    end
    idle(3 * FRAME_C);
    chkGap = 1'b0;
    check(rxCount == cnt0 + 256, "R7", "sweep frame count", rxCount, cnt0 + 256);
    check(expQ.size() == 0, "R6", "bytes left undelivered", expQ.size(), 0);
    check(txLine == 1'b1, "R8", "line after sweep", txLine, 1);

    finishRun();
  end
endmodule